// File: doc/BRIEF.md
# SDRAM Command Decoder with Mode and Color Registers

This block is the command front end of a behavioural two-bank synchronous DRAM model. On every rising clock edge it samples chip select, the three strobes (row, column, write), the special-function select, the bank select and a 10-bit address. From these it works out one command per cycle and keeps the state that later stages need: the mode register fields, a 32-bit color register and whether each bank is open or closed.

All results are registered. The command, its target banks, its address and the number of columns it touches appear on the outputs after the same edge that sampled the inputs. The mode fields, color value, bank state and a sticky protocol-error flag update on that edge as well. Array storage, data-path timing and refresh counting are handled elsewhere.

Top module: `sdram_cmd_front`

## Requirements
- R1: After reset, `cmd` is 0 (no operation), `cmd_banks`, `bank_open`, `proto_err`, `color`, `burst_interleave`, `write_single` and `test_mode` are 0, `cas_lat` is 3, and the burst length is 1. A read therefore reports `cmd_cols` = 1.
- R2: While `cs_n` is high, the command is reported as 0 and no bank, mode, color or error state changes, whatever the other inputs hold.
- R3: With `cs_n` low, `{ras_n,cas_n,we_n}` decodes as follows: 111 gives no operation (0), 011 activate (1), 101 read (2), 100 write (3), or block write (4) when `dsf` is 1, 010 precharge (5), 000 mode set (6), or special mode set (7) when `dsf` is 1, and 001 or 110 other (8).
- R4: An activate opens the bank selected by `ba`. `ba` = 0 is bank A, shown as `cmd_banks`/`bank_open` bit 0, and `ba` = 1 is bank B, bit 1. The activate reports the full 10-bit address as the row on `cmd_addr`.
- R5: A precharge with `addr[9]` high targets and closes both banks (`cmd_banks` = 11). With `addr[9]` low it targets and closes only the bank chosen by `ba`.
- R6: A read, write or block write reports `addr[9]` on `cmd_auto_pre` and its single target bank on `cmd_banks`. When `addr[9]` is 1, that bank is closed in the same update.
- R7: A mode set with `addr[8:7]` = 00 and legal codes loads the burst length code from `addr[2:0]` and the burst type from `addr[3]` (1 = interleave). It also loads the latency from `addr[6:4]`, where 010 gives `cas_lat` 2 and 011 gives 3. Burst codes 000/001/010/011/111 make a read report 1/2/4/8/256 columns.
- R8: A mode set with `addr[8:7]` = 00 whose latency code is not 010 or 011 is rejected. So is one whose burst code is 100, 101 or 110, or 111 together with interleave. A rejected mode set leaves every mode field unchanged and sets `proto_err`.
- R9: A mode set with `addr[8:7]` not 00 sets `test_mode`, changes no other mode field and raises no error. A later accepted normal mode set clears `test_mode`.
- R10: `addr[9]` of an accepted mode set drives `write_single`. While it is 1, a write reports `cmd_cols` = 1 and a read still reports the full burst length. While it is 0, a write reports the burst length.
- R11: A block write reports `cmd_cols` = 8 and a column on `cmd_addr` equal to `addr[7:0]` with its three low bits cleared.
- R12: A special mode set with `addr[5]` = 1 loads `color` from `dq_in`. With `addr[5]` = 0 it leaves `color` unchanged. No other command alters `color`.
- R13: A read, write or block write to a bank that is closed at the time it is sampled sets `proto_err`. The flag then stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| dsf | input | 1 | Special-function select |
| ba | input | 1 | Bank select (0 = A, 1 = B) |
| addr | input | 10 | Row, column or mode address |
| dq_in | input | 32 | Data bus value used by a color load |
| cmd | output | 4 | Decoded command code (R3) |
| cmd_banks | output | 2 | Banks targeted by the command |
| cmd_addr | output | 10 | Row for activate, column for accesses |
| cmd_cols | output | 9 | Columns touched by an access |
| cmd_auto_pre | output | 1 | Access requests auto precharge |
| bank_open | output | 2 | Open state of banks B and A |
| cas_lat | output | 2 | Current CAS latency (2 or 3) |
| burst_interleave | output | 1 | Burst type is interleave |
| write_single | output | 1 | Writes are single-beat |
| test_mode | output | 1 | Last mode set selected a test mode |
| color | output | 32 | Color register |
| proto_err | output | 1 | Sticky protocol-error flag |

## Verification
Two effects can fall on the same edge: an access carrying `addr[9]` closes its bank, and the same access is judged against the bank state for the closed-bank error. The bench provokes this with an auto-precharge read to an open bank, which must report auto precharge, close the bank and leave the error clear. A second read to that now-closed bank must then raise the error. It also sends an auto-precharge access to a bank that was never opened, where the error and the closure must both appear after that single edge.

// File: rtl/sdram_cmd_front.sv
module sdram_cmd_front #(
  parameter int AW        = 10,
  parameter int COLW      = 8,
  parameter int DW        = 32,
  parameter int COLOR_SEL = 5,
  parameter int BLK_COLS  = 8
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              dsf,
  input  logic              ba,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     dq_in,
  output logic [3:0]        cmd,
  output logic [1:0]        cmd_banks,
  output logic [AW-1:0]     cmd_addr,
  output logic [COLW:0]     cmd_cols,
  output logic              cmd_auto_pre,
  output logic [1:0]        bank_open,
  output logic [1:0]        cas_lat,
  output logic              burst_interleave,
  output logic              write_single,
  output logic              test_mode,
  output logic [DW-1:0]     color,
  output logic              proto_err
);
  localparam int CNTW    = COLW + 1;
  localparam int BLK_LSB = $clog2(BLK_COLS);
  localparam int AP_BIT  = AW - 1;
  localparam int OP_HI   = AW - 2;
  localparam int OP_LO   = AW - 3;

  localparam logic [3:0] C_NOP  = 4'd0;
  localparam logic [3:0] C_ACT  = 4'd1;
  localparam logic [3:0] C_RD   = 4'd2;
  localparam logic [3:0] C_WR   = 4'd3;
  localparam logic [3:0] C_BW   = 4'd4;
  localparam logic [3:0] C_PRE  = 4'd5;
  localparam logic [3:0] C_MRS  = 4'd6;
  localparam logic [3:0] C_SMRS = 4'd7;
  localparam logic [3:0] C_OTH  = 4'd8;

  logic [2:0] bl_q;
  logic       cl3_q;
  logic [3:0] dec;

  always_comb begin
    dec = C_NOP;
    if (!cs_n) begin
      case ({ras_n, cas_n, we_n})
        3'b011:         dec = C_ACT;
        3'b101:         dec = C_RD;
        3'b100:         dec = dsf ? C_BW : C_WR;
        3'b010:         dec = C_PRE;
        3'b000:         dec = dsf ? C_SMRS : C_MRS;
        3'b001, 3'b110: dec = C_OTH;
        default:        dec = C_NOP;
      endcase
    end
  end

  logic [1:0] ba_hot, pre_mask;
  logic       bank_hit;
  assign ba_hot   = ba ? 2'b10 : 2'b01;
  assign pre_mask = addr[AP_BIT] ? 2'b11 : ba_hot;
  assign bank_hit = |(bank_open & ba_hot);

  logic [2:0] bl_c, cl_c;
  logic       mr_normal, cl_ok, bl_ok;
  assign bl_c      = addr[2:0];
  assign cl_c      = addr[6:4];
  assign mr_normal = (addr[OP_HI:OP_LO] == 2'b00);
  assign cl_ok     = (cl_c == 3'b010) || (cl_c == 3'b011);
  assign bl_ok     = !bl_c[2] || ((bl_c == 3'b111) && !addr[3]);

  logic [AW-1:0] col_plain, col_blk;
  assign col_plain = AW'(addr[COLW-1:0]);
  assign col_blk   = AW'({addr[COLW-1:BLK_LSB], {BLK_LSB{1'b0}}});

  logic [CNTW-1:0] burst_cols;
  assign burst_cols = (bl_q == 3'b111) ? (CNTW'(1) << COLW) : (CNTW'(1) << bl_q[1:0]);

  assign cas_lat = cl3_q ? 2'd3 : 2'd2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd              <= C_NOP;
      cmd_banks        <= '0;
      cmd_addr         <= '0;
      cmd_cols         <= '0;
      cmd_auto_pre     <= 1'b0;
      bank_open        <= '0;
      bl_q             <= 3'b000;
      cl3_q            <= 1'b1;
      burst_interleave <= 1'b0;
      write_single     <= 1'b0;
      test_mode        <= 1'b0;
      color            <= '0;
      proto_err        <= 1'b0;
    end else begin
      cmd          <= dec;
      cmd_banks    <= '0;
      cmd_addr     <= '0;
      cmd_cols     <= '0;
      cmd_auto_pre <= 1'b0;
      case (dec)
        C_ACT: begin
          cmd_banks <= ba_hot;
          cmd_addr  <= addr;
          bank_open <= bank_open | ba_hot;
        end
        C_RD, C_WR, C_BW: begin
          cmd_banks    <= ba_hot;
          cmd_auto_pre <= addr[AP_BIT];
          if (dec == C_BW) begin
            cmd_addr <= col_blk;
            cmd_cols <= CNTW'(BLK_COLS);
          end else begin
            cmd_addr <= col_plain;
            cmd_cols <= (dec == C_WR && write_single) ? CNTW'(1) : burst_cols;
          end
          if (addr[AP_BIT]) bank_open <= bank_open & ~ba_hot;
          if (!bank_hit) proto_err <= 1'b1;
        end
        C_PRE: begin
          cmd_banks <= pre_mask;
          bank_open <= bank_open & ~pre_mask;
        end
        C_MRS: begin
          if (!mr_normal) begin
            test_mode <= 1'b1;
          end else if (cl_ok && bl_ok) begin
            bl_q             <= bl_c;
            burst_interleave <= addr[3];
            cl3_q            <= cl_c[0];
            write_single     <= addr[AP_BIT];
            test_mode        <= 1'b0;
          end else begin
            proto_err <= 1'b1;
          end
        end
        C_SMRS: begin
          if (addr[COLOR_SEL]) color <= dq_in;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sdram_cmd_front_chk.sv
module sdram_cmd_front_chk #(
  parameter int AW       = 10,
  parameter int DW       = 32,
  parameter int CNTW     = 9,
  parameter int BLK_COLS = 8
)(
  input logic            clk,
  input logic            rst_n,
  input logic [3:0]      cmd,
  input logic [1:0]      cmd_banks,
  input logic [AW-1:0]   cmd_addr,
  input logic [CNTW-1:0] cmd_cols,
  input logic            cmd_auto_pre,
  input logic [1:0]      bank_open,
  input logic [1:0]      cas_lat,
  input logic            write_single,
  input logic [DW-1:0]   color,
  input logic            proto_err
);
  localparam logic [3:0] K_RD = 4'd2, K_WR = 4'd3, K_BW = 4'd4, K_PRE = 4'd5, K_SMRS = 4'd7;

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err); // R13

  AST_ACCESS_ONE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == K_RD || cmd == K_WR || cmd == K_BW) |-> $countones(cmd_banks) == 1); // R6

  AST_BLK_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == K_BW) |-> ((cmd_addr & AW'(BLK_COLS - 1)) == '0 && cmd_cols == CNTW'(BLK_COLS))); // R11

  AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == K_WR && write_single) |-> cmd_cols == CNTW'(1)); // R10

  AST_COLOR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd != K_SMRS) |-> $stable(color)); // R12

  AST_PRE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == K_PRE) |-> (bank_open & cmd_banks) == 2'b00); // R5

  AST_AUTO_PRE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_auto_pre |-> (bank_open & cmd_banks) == 2'b00); // R6

  AST_LATENCY_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_lat == 2'd2) || (cas_lat == 2'd3)); // R7
endmodule

bind sdram_cmd_front sdram_cmd_front_chk #(
  .AW(AW), .DW(DW), .CNTW(COLW + 1), .BLK_COLS(BLK_COLS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd(cmd), .cmd_banks(cmd_banks), .cmd_addr(cmd_addr),
  .cmd_cols(cmd_cols), .cmd_auto_pre(cmd_auto_pre), .bank_open(bank_open),
  .cas_lat(cas_lat), .write_single(write_single), .color(color), .proto_err(proto_err)
);

// File: tb/sdram_cmd_front_tb.sv
`timescale 1ns/1ps
module sdram_cmd_front_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, cs_n, ras_n, cas_n, we_n, dsf, ba;
  logic [9:0]  addr;
  logic [31:0] dq_in;
  logic [3:0]  cmd;
  logic [1:0]  cmd_banks, bank_open, cas_lat;
  logic [9:0]  cmd_addr;
  logic [8:0]  cmd_cols;
  logic        cmd_auto_pre, burst_interleave, write_single, test_mode, proto_err;
  logic [31:0] color;

  sdram_cmd_front u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .dsf(dsf), .ba(ba), .addr(addr), .dq_in(dq_in), .cmd(cmd), .cmd_banks(cmd_banks),
    .cmd_addr(cmd_addr), .cmd_cols(cmd_cols), .cmd_auto_pre(cmd_auto_pre),
    .bank_open(bank_open), .cas_lat(cas_lat), .burst_interleave(burst_interleave),
    .write_single(write_single), .test_mode(test_mode), .color(color), .proto_err(proto_err)
  );

  int checks = 0;
  int errors = 0;

  localparam logic [2:0] E_ACT = 3'b011, E_RD = 3'b101, E_WR = 3'b100, E_PRE = 3'b010, E_MRS = 3'b000, E_NOP = 3'b111;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_idle();
    cs_n = 1'b1; {ras_n, cas_n, we_n} = E_NOP; dsf = 1'b0; ba = 1'b0; addr = '0; dq_in = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    set_idle();
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic issue(input logic cs, input logic [2:0] rcw, input logic d, input logic b,
                       input logic [9:0] a, input logic [31:0] dv);
    cs_n = cs; {ras_n, cas_n, we_n} = rcw; dsf = d; ba = b; addr = a; dq_in = dv;
    @(negedge clk);
    set_idle();
  endtask

  function automatic logic [3:0] exp_cmd(input logic cs, input logic [2:0] rcw, input logic d);
    if (cs) return 4'd0;
    case (rcw)
      3'b011: return 4'd1;
      3'b101: return 4'd2;
      3'b100: return d ? 4'd4 : 4'd3;
      3'b010: return 4'd5;
      3'b000: return d ? 4'd7 : 4'd6;
      3'b001, 3'b110: return 4'd8;
      default: return 4'd0;
    endcase
  endfunction

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    set_idle();
    rst_n = 1'b0;
    do_reset();

    // R1 reset state
    chk("R1 cmd", 32'(cmd), 0);
    chk("R1 banks", 32'(cmd_banks), 0);
    chk("R1 open", 32'(bank_open), 0);
    chk("R1 err", 32'(proto_err), 0);
    chk("R1 color", color, 0);
    chk("R1 cas_lat", 32'(cas_lat), 3);
    chk("R1 interleave", 32'(burst_interleave), 0);
    chk("R1 single", 32'(write_single), 0);
    chk("R1 test", 32'(test_mode), 0);
    issue(0, E_ACT, 0, 0, 10'h001, 0);
    issue(0, E_RD, 0, 0, 10'h005, 0);
    chk("R1 default burst 1", 32'(cmd_cols), 1);

    // R3 / R2 decode sweep over cs, strobes and dsf
    for (int cs = 0; cs < 2; cs++)
      for (int r = 0; r < 8; r++)
        for (int d = 0; d < 2; d++) begin
          do_reset();
          issue(cs[0], r[2:0], d[0], 0, 10'h020, 32'hDEAD_BEEF);
          chk(cs ? "R2 cs high nop" : "R3 decode", 32'(cmd), 32'(exp_cmd(cs[0], r[2:0], d[0])));
          if (cs) begin
            chk("R2 no bank change", 32'(bank_open), 0);
            chk("R2 no color change", color, 0);
            chk("R2 no error", 32'(proto_err), 0);
          end
        end

    // R2 chip select high hides a state-changing command
    do_reset();
    issue(0, E_ACT, 0, 0, 10'h010, 0);
    issue(1, E_PRE, 0, 0, 10'h200, 0);
    chk("R2 precharge ignored", 32'(bank_open), 32'b01);
    issue(1, E_MRS, 0, 0, 10'h023, 0);
    chk("R2 mode set ignored", 32'(cas_lat), 3);

    // R4 activate
    do_reset();
    issue(0, E_ACT, 0, 0, 10'h2AB, 0);
    chk("R4 row", 32'(cmd_addr), 32'h2AB);
    chk("R4 bank A hot", 32'(cmd_banks), 32'b01);
    chk("R4 open A", 32'(bank_open), 32'b01);
    issue(0, E_ACT, 0, 1, 10'h155, 0);
    chk("R4 bank B hot", 32'(cmd_banks), 32'b10);
    chk("R4 open both", 32'(bank_open), 32'b11);

    // R5 precharge single and all
    issue(0, E_PRE, 0, 1, 10'h000, 0);
    chk("R5 single banks", 32'(cmd_banks), 32'b10);
    chk("R5 single close", 32'(bank_open), 32'b01);
    issue(0, E_ACT, 0, 1, 10'h000, 0);
    issue(0, E_PRE, 0, 0, 10'h200, 0);
    chk("R5 all banks", 32'(cmd_banks), 32'b11);
    chk("R5 all close", 32'(bank_open), 32'b00);

    // R6 / R13 auto precharge meeting the closed-bank judgement
    do_reset();
    issue(0, E_ACT, 0, 1, 10'h000, 0);
    issue(0, E_RD, 0, 1, 10'h210, 0);
    chk("R6 auto pre flag", 32'(cmd_auto_pre), 1);
    chk("R6 column", 32'(cmd_addr), 32'h10);
    chk("R6 bank closed", 32'(bank_open), 0);
    chk("R13 open access no error", 32'(proto_err), 0);
    issue(0, E_RD, 0, 1, 10'h010, 0);
    chk("R13 closed access error", 32'(proto_err), 1);
    issue(0, E_NOP, 0, 0, 10'h000, 0);
    chk("R13 sticky", 32'(proto_err), 1);
    do_reset();
    issue(0, E_WR, 0, 0, 10'h203, 0);
    chk("R13 auto pre to closed bank error", 32'(proto_err), 1);
    chk("R6 auto pre to closed bank stays closed", 32'(bank_open), 0);
    chk("R6 write banks", 32'(cmd_banks), 32'b01);

    // R7 / R8 sweep of mode codes
    for (int v = 0; v < 128; v++) begin
      logic [2:0] blc, clc;
      logic il, ok;
      blc = v[2:0]; il = v[3]; clc = v[6:4];
      ok = ((clc == 3'd2) || (clc == 3'd3)) && ((blc < 3'd4) || (blc == 3'd7 && !il));
      do_reset();
      issue(0, E_MRS, 0, 0, 10'(v), 0);
      chk("R8 reserved flag", 32'(proto_err), 32'(!ok));
      if (ok) begin
        chk("R7 latency", 32'(cas_lat), 32'(clc));
        chk("R7 interleave", 32'(burst_interleave), 32'(il));
        issue(0, E_ACT, 0, 1, 10'h000, 0);
        issue(0, E_RD, 0, 1, 10'h003, 0);
        chk("R7 read cols", 32'(cmd_cols), (blc == 3'd7) ? 256 : (1 << blc));
      end else begin
        chk("R8 latency kept", 32'(cas_lat), 3);
        chk("R8 interleave kept", 32'(burst_interleave), 0);
      end
    end

    // R9 test mode
    do_reset();
    issue(0, E_MRS, 0, 0, 10'h080, 0);
    chk("R9 test set", 32'(test_mode), 1);
    chk("R9 no error", 32'(proto_err), 0);
    chk("R9 latency kept", 32'(cas_lat), 3);
    issue(0, E_MRS, 0, 0, 10'h023, 0);
    chk("R9 test cleared", 32'(test_mode), 0);
    chk("R9 normal load", 32'(cas_lat), 2);

    // R10 single writes
    do_reset();
    issue(0, E_MRS, 0, 0, 10'h232, 0);
    chk("R10 single on", 32'(write_single), 1);
    issue(0, E_ACT, 0, 0, 10'h000, 0);
    issue(0, E_WR, 0, 0, 10'h007, 0);
    chk("R10 write cols", 32'(cmd_cols), 1);
    issue(0, E_RD, 0, 0, 10'h007, 0);
    chk("R10 read burst", 32'(cmd_cols), 4);
    issue(0, E_MRS, 0, 0, 10'h032, 0);
    issue(0, E_WR, 0, 0, 10'h007, 0);
    chk("R10 write burst", 32'(cmd_cols), 4);

    // R11 block write sweep
    do_reset();
    issue(0, E_ACT, 0, 1, 10'h000, 0);
    for (int c = 0; c < 256; c += 37) begin
      issue(0, E_WR, 1, 1, 10'(c), 0);
      chk("R11 code", 32'(cmd), 4);
      chk("R11 aligned col", 32'(cmd_addr), 32'(c & 8'hF8));
      chk("R11 cols", 32'(cmd_cols), 8);
      chk("R11 bank", 32'(cmd_banks), 32'b10);
    end

    // R12 color register
    do_reset();
    issue(0, E_MRS, 1, 0, 10'h020, 32'hA5A5_1234);
    chk("R12 load", color, 32'hA5A5_1234);
    issue(0, E_MRS, 1, 0, 10'h000, 32'hFFFF_FFFF);
    chk("R12 unchanged", color, 32'hA5A5_1234);
    chk("R12 mode untouched", 32'(cas_lat), 3);
    issue(0, E_MRS, 0, 0, 10'h022, 32'h0000_0000);
    chk("R12 normal mode set keeps color", color, 32'hA5A5_1234);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule